// File: doc/BRIEF.md
# Byte Mailbox Command Engine

This engine sits on the host side of a one-byte-wide mailbox that connects it to a microcontroller. A requester hands it one command at a time. The command is either a raw command whose payload bytes arrive over a streaming handshake, a 32-bit register write, or a bit-field write. The engine frames the command behind a four-byte header and pushes it into the mailbox byte by byte. Before every byte it waits for the mailbox to have room.

When the requester asks for a reply, the engine reads the reply header and compares it with the expected opcode, module ID and length. On a match it streams the reply payload to the requester. On a mismatch it reads and discards the bytes the header announced, then reports an invalid reply. Every wait on a mailbox flag is polled at a fixed interval and abandoned after a bounded number of polls. An optional check compares three reply bytes against a 24-bit target address, which suits auxiliary-channel write acknowledgements. Each command ends with a one-cycle done pulse and a status code.

Top module: `mbox_cmd_engine`

## Requirements
- R1: Every message sent begins with four header bytes in this order: opcode, module ID, payload length bits 15:8, payload length bits 7:0. The payload bytes follow at once.
- R2: A byte is written (`mb_wr_en`) only in a cycle where `mb_full` is low, and read (`mb_rd_en`) only in a cycle where `mb_empty` is low. The two strobes are never high together.
- R3: A received byte is taken from `mb_rd_data[7:0]`. Bits 31:8 have no effect on headers, on streamed data or on checks.
- R4: A raw command (`req_kind`=0) sends `req_len` payload bytes taken in order from the payload handshake. With `req_len`=0 only the four header bytes are written.
- R5: A register write (`req_kind`=1) has a payload length of 6. The payload is `req_addr` most significant byte first, then `req_value` most significant byte first.
- R6: A bit-field write (`req_kind`=2) has a payload length of 8. The payload is `req_addr` (2 bytes, big-endian), `req_start`, `req_bits`, then `req_value` (4 bytes, big-endian).
- R7: When `req_expect` is set and the reply header matches the request opcode, the request module ID and `req_rsp_len`, the reply payload bytes appear in order on `rsp_data`. `rsp_data` is held stable while `rsp_valid` is high and `rsp_ready` is low. The status is OK (0).
- R8: If the reply opcode, module ID or 16-bit length differs from the expected values, the engine reads and discards exactly the declared number of bytes, streams nothing, and reports invalid reply (2).
- R9: A flag wait is sampled every `POLL_CYC` cycles. After `POLL_LIMIT` further samples that all see the flag set, the command ends with status timeout (1).
- R10: A timeout while discarding a mismatching reply ends the discard at once and reports timeout (1), not invalid reply.
- R11: With `req_chk_addr` set, reply payload bytes 2, 3 and 4 must equal `req_addr24` bits 23:16, 15:8 and 7:0. Any difference gives status invalid reply (2) once the payload has been streamed.
- R12: `done` is a one-cycle pulse per command with `done_status` in {0,1,2}. `req_ready` is high only while idle, including directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Engine idle, accepts a command |
| req_kind | input | 2 | 0 raw, 1 register write, 2 bit-field write |
| req_opcode | input | 8 | Opcode sent and expected in the reply |
| req_module | input | 8 | Module ID sent and expected in the reply |
| req_len | input | 16 | Raw payload length |
| req_addr | input | 16 | Register address for kinds 1 and 2 |
| req_start | input | 8 | First bit of the field (kind 2) |
| req_bits | input | 8 | Field width in bits (kind 2) |
| req_value | input | 32 | Value for kinds 1 and 2 |
| req_expect | input | 1 | A reply is expected |
| req_rsp_len | input | 16 | Expected reply payload length |
| req_chk_addr | input | 1 | Check reply bytes 2 to 4 against req_addr24 |
| req_addr24 | input | 24 | Target address for the reply check |
| pay_valid | input | 1 | Raw payload byte valid |
| pay_data | input | 8 | Raw payload byte |
| pay_ready | output | 1 | Payload byte taken |
| rsp_valid | output | 1 | Reply payload byte valid |
| rsp_data | output | 8 | Reply payload byte |
| rsp_ready | input | 1 | Requester takes the reply byte |
| done | output | 1 | Command finished (one cycle) |
| done_status | output | 2 | 0 OK, 1 timeout, 2 invalid reply |
| mb_full | input | 1 | Mailbox write side full |
| mb_wr_en | output | 1 | Write strobe |
| mb_wr_data | output | 8 | Byte written |
| mb_empty | input | 1 | Mailbox read side empty |
| mb_rd_en | output | 1 | Read strobe, pops the head word |
| mb_rd_data | input | 32 | Head word of the read side |

## Verification
The hardest case to reach from the ports is a timeout in the middle of discarding a bad reply. The reply must carry a mismatching header, and the mailbox must then run dry before the declared byte count has been consumed. The bench preloads a header whose opcode is altered and whose declared length is larger than the bytes it supplies. The empty flag then stays high until the shortened poll limit runs out. A separate case holds the full flag high from the first header byte to reach the transmit timeout.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned HDR_N = 4;
  localparam logic [1:0] K_RAW   = 2'd0;
  localparam logic [1:0] K_REG   = 2'd1;
  localparam logic [1:0] K_FIELD = 2'd2;
  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_TMO  = 2'd1;
  localparam logic [1:0] ST_BAD  = 2'd2;
  typedef enum logic [2:0] {
    S_IDLE, S_TX, S_RXH, S_RXP, S_OUT, S_DRAIN
  } eng_state_e;
endpackage

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int unsigned POLL_CYC   = 250000,
  parameter int unsigned POLL_LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic busy_i,
  output logic grant_o,
  output logic expire_o
);
  localparam int unsigned PH_W = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int unsigned FL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(POLL_CYC - 1);
  localparam logic [FL_W-1:0] FL_MAX  = FL_W'(POLL_LIMIT);

  logic [PH_W-1:0] ph_q, ph_n;
  logic [FL_W-1:0] fl_q, fl_n;
  logic            probe;

  assign probe    = (ph_q == '0);
  assign grant_o  = run_i && probe && !busy_i;
  assign expire_o = run_i && probe && busy_i && (fl_q == FL_MAX);

  always_comb begin
    ph_n = ph_q;
    fl_n = fl_q;
    if (!run_i || grant_o) begin
      ph_n = '0;
      fl_n = '0;
    end else begin
      ph_n = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      if (probe && busy_i && !expire_o) fl_n = fl_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      fl_q <= '0;
    end else begin
      ph_q <= ph_n;
      fl_q <= fl_n;
    end
  end
endmodule

// File: rtl/mbox_hdr_check.sv
module mbox_hdr_check (
  input  logic [23:0] hdr_hi,
  input  logic [7:0]  hdr_lo,
  input  logic [7:0]  exp_opc,
  input  logic [7:0]  exp_mod,
  input  logic [15:0] exp_len,
  output logic        match,
  output logic [15:0] decl_len
);
  assign decl_len = {hdr_hi[7:0], hdr_lo};
  assign match    = (hdr_hi[23:16] == exp_opc) && (hdr_hi[15:8] == exp_mod) &&
                    (decl_len == exp_len);
endmodule

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine
  import mbox_pkg::*;
#(
  parameter int unsigned POLL_CYC   = 250000,
  parameter int unsigned POLL_LIMIT = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [7:0]  req_opcode,
  input  logic [7:0]  req_module,
  input  logic [15:0] req_len,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_start,
  input  logic [7:0]  req_bits,
  input  logic [31:0] req_value,
  input  logic        req_expect,
  input  logic [15:0] req_rsp_len,
  input  logic        req_chk_addr,
  input  logic [23:0] req_addr24,
  input  logic        pay_valid,
  input  logic [7:0]  pay_data,
  output logic        pay_ready,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  input  logic        rsp_ready,
  output logic        done,
  output logic [1:0]  done_status,
  input  logic        mb_full,
  output logic        mb_wr_en,
  output logic [7:0]  mb_wr_data,
  input  logic        mb_empty,
  output logic        mb_rd_en,
  input  logic [31:0] mb_rd_data
);
  localparam int unsigned SH_W = 8 * (HDR_N + 8);
  localparam int unsigned CNT_W = 17;

  eng_state_e        state_q, state_n;
  logic [CNT_W-1:0]  idx_q, idx_n, tot_q, tot_n, idx_inc;
  logic [SH_W-1:0]   sh_q, sh_n;
  logic [1:0]        kind_q, kind_n, stat_q, stat_n;
  logic [7:0]        opc_q, opc_n, mod_q, mod_n, rsp_q, rsp_n;
  logic [15:0]       elen_q, elen_n, len16, decl_len;
  logic              exp_q, exp_n, chk_q, chk_n, bad_q, bad_n, done_q, done_n;
  logic [23:0]       caddr_q, caddr_n, rxh_q, rxh_n;
  logic [63:0]       body;
  logic              run, busy, grant, expire, from_pay, hdr_ok, addr_hit;
  logic [7:0]        rx_byte, abyte;

  mbox_poll_timer #(.POLL_CYC(POLL_CYC), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run), .busy_i(busy),
    .grant_o(grant), .expire_o(expire)
  );

  mbox_hdr_check u_hchk (
    .hdr_hi(rxh_q), .hdr_lo(rx_byte), .exp_opc(opc_q), .exp_mod(mod_q),
    .exp_len(elen_q), .match(hdr_ok), .decl_len(decl_len)
  );

  assign rx_byte    = mb_rd_data[7:0];
  assign idx_inc    = idx_q + 1'b1;
  assign from_pay   = (kind_q == K_RAW) && (idx_q >= CNT_W'(HDR_N));
  assign mb_wr_data = from_pay ? pay_data : sh_q[SH_W-1 -: 8];
  assign rsp_valid  = (state_q == S_OUT);
  assign rsp_data   = rsp_q;
  assign done       = done_q;
  assign done_status = stat_q;
  assign addr_hit   = chk_q && (idx_q >= CNT_W'(2)) && (idx_q <= CNT_W'(4));
  assign abyte      = (idx_q == CNT_W'(2)) ? caddr_q[23:16] :
                      (idx_q == CNT_W'(3)) ? caddr_q[15:8] : caddr_q[7:0];

  always_comb begin
    case (req_kind)
      K_REG:   begin len16 = 16'd6; body = {req_addr, req_value, 16'h0000}; end
      K_FIELD: begin len16 = 16'd8; body = {req_addr, req_start, req_bits, req_value}; end
      default: begin len16 = req_len; body = 64'h0; end
    endcase
  end

  always_comb begin
    state_n = state_q; idx_n = idx_q; tot_n = tot_q; sh_n = sh_q;
    kind_n = kind_q; opc_n = opc_q; mod_n = mod_q; elen_n = elen_q;
    exp_n = exp_q; chk_n = chk_q; caddr_n = caddr_q; rxh_n = rxh_q;
    bad_n = bad_q; rsp_n = rsp_q; stat_n = stat_q; done_n = 1'b0;
    run = 1'b0; busy = mb_empty;
    req_ready = 1'b0; pay_ready = 1'b0; mb_wr_en = 1'b0; mb_rd_en = 1'b0;
    case (state_q)
      S_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          kind_n = req_kind; opc_n = req_opcode; mod_n = req_module;
          elen_n = req_rsp_len; exp_n = req_expect; chk_n = req_chk_addr;
          caddr_n = req_addr24; bad_n = 1'b0; idx_n = '0;
          tot_n = {1'b0, len16} + CNT_W'(HDR_N);
          sh_n = {req_opcode, req_module, len16, body};
          state_n = S_TX;
        end
      end
      S_TX: begin
        busy = mb_full;
        run = !from_pay || pay_valid;
        if (grant) begin
          mb_wr_en = 1'b1;
          pay_ready = from_pay;
          sh_n = {sh_q[SH_W-9:0], 8'h00};
          idx_n = idx_inc;
          if (idx_inc == tot_q) begin
            idx_n = '0;
            if (exp_q) state_n = S_RXH;
            else begin done_n = 1'b1; stat_n = ST_OK; state_n = S_IDLE; end
          end
        end else if (expire) begin
          done_n = 1'b1; stat_n = ST_TMO; state_n = S_IDLE;
        end
      end
      S_RXH, S_RXP, S_DRAIN: begin
        run = 1'b1;
        if (grant) begin
          mb_rd_en = 1'b1;
          if (state_q == S_RXH) begin
            rxh_n = {rxh_q[15:0], rx_byte};
            idx_n = idx_inc;
            if (idx_q == CNT_W'(HDR_N - 1)) begin
              idx_n = '0;
              tot_n = {1'b0, decl_len};
              if (decl_len == 16'd0) begin
                done_n = 1'b1; stat_n = hdr_ok ? ST_OK : ST_BAD; state_n = S_IDLE;
              end else state_n = hdr_ok ? S_RXP : S_DRAIN;
            end
          end else if (state_q == S_RXP) begin
            rsp_n = rx_byte;
            if (addr_hit && (rx_byte != abyte)) bad_n = 1'b1;
            state_n = S_OUT;
          end else begin
            idx_n = idx_inc;
            if (idx_inc == tot_q) begin
              done_n = 1'b1; stat_n = ST_BAD; state_n = S_IDLE;
            end
          end
        end else if (expire) begin
          done_n = 1'b1; stat_n = ST_TMO; state_n = S_IDLE;
        end
      end
      S_OUT: begin
        if (rsp_ready) begin
          idx_n = idx_inc;
          if (idx_inc == tot_q) begin
            done_n = 1'b1; stat_n = bad_q ? ST_BAD : ST_OK; state_n = S_IDLE;
          end else state_n = S_RXP;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; idx_q <= '0; tot_q <= '0; sh_q <= '0;
      kind_q <= K_RAW; opc_q <= '0; mod_q <= '0; elen_q <= '0;
      exp_q <= 1'b0; chk_q <= 1'b0; caddr_q <= '0; rxh_q <= '0;
      bad_q <= 1'b0; rsp_q <= '0; stat_q <= ST_OK; done_q <= 1'b0;
    end else begin
      state_q <= state_n; idx_q <= idx_n; tot_q <= tot_n; sh_q <= sh_n;
      kind_q <= kind_n; opc_q <= opc_n; mod_q <= mod_n; elen_q <= elen_n;
      exp_q <= exp_n; chk_q <= chk_n; caddr_q <= caddr_n; rxh_q <= rxh_n;
      bad_q <= bad_n; rsp_q <= rsp_n; stat_q <= stat_n; done_q <= done_n;
    end
  end
endmodule

// File: rtl/mbox_cmd_engine_chk.sv
module mbox_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       done,
  input logic [1:0] done_status,
  input logic       mb_full,
  input logic       mb_wr_en,
  input logic       mb_empty,
  input logic       mb_rd_en
);
  p_wr_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr_en |-> !mb_full);
  p_rd_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd_en |-> !mb_empty);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_wr_en && mb_rd_en));
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_status_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_status != 2'd3));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mb_wr_en && !mb_rd_en));
endmodule

bind mbox_cmd_engine mbox_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .done(done),
  .done_status(done_status), .mb_full(mb_full), .mb_wr_en(mb_wr_en),
  .mb_empty(mb_empty), .mb_rd_en(mb_rd_en)
);

// File: tb/sim_mbox_cmd_engine.sv
module sim_mbox_cmd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_opcode = '0, req_module = '0, req_start = '0, req_bits = '0;
  logic [15:0] req_len = '0, req_addr = '0, req_rsp_len = '0;
  logic [31:0] req_value = '0;
  logic        req_expect = 1'b0, req_chk_addr = 1'b0;
  logic [23:0] req_addr24 = '0;
  logic        pay_valid, pay_ready, rsp_valid, rsp_ready = 1'b1;
  logic [7:0]  pay_data, rsp_data, mb_wr_data;
  logic        done, mb_full, mb_wr_en, mb_empty, mb_rd_en;
  logic [1:0]  done_status;
  logic [31:0] mb_rd_data;

  logic [7:0]  tx_log [0:2047];
  logic [7:0]  rx_q   [0:2047];
  logic [23:0] rx_hi  [0:2047];
  logic [7:0]  rsp_log[0:2047];
  logic [7:0]  pay_mem[0:2047];
  int tx_n = 0, rx_n = 0, rx_rd = 0, rsp_n = 0, pay_n = 0, pay_idx = 0;
  int acc_cnt = 0, done_cnt = 0, gate_viol = 0, cyc = 0;
  logic [1:0] last_st = '0;
  logic full_force = 1'b0, full_rnd = 1'b0, empty_rnd = 1'b0, pay_en = 1'b1, stress = 1'b0;
  int total = 0, bad = 0;

  assign mb_full    = full_force || full_rnd;
  assign mb_empty   = (rx_rd >= rx_n) || empty_rnd;
  assign mb_rd_data = {rx_hi[rx_rd[10:0]], rx_q[rx_rd[10:0]]};
  assign pay_valid  = pay_en && (pay_idx < pay_n);
  assign pay_data   = pay_mem[pay_idx[10:0]];

  mbox_cmd_engine #(.POLL_CYC(3), .POLL_LIMIT(20)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_opcode(req_opcode), .req_module(req_module),
    .req_len(req_len), .req_addr(req_addr), .req_start(req_start),
    .req_bits(req_bits), .req_value(req_value), .req_expect(req_expect),
    .req_rsp_len(req_rsp_len), .req_chk_addr(req_chk_addr), .req_addr24(req_addr24),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .done(done), .done_status(done_status), .mb_full(mb_full),
    .mb_wr_en(mb_wr_en), .mb_wr_data(mb_wr_data), .mb_empty(mb_empty),
    .mb_rd_en(mb_rd_en), .mb_rd_data(mb_rd_data)
  );

  // mailbox and requester-side model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mb_wr_en) begin
      tx_log[tx_n[10:0]] <= mb_wr_data;
      tx_n <= tx_n + 1;
      if (mb_full) gate_viol <= gate_viol + 1;
    end
    if (mb_rd_en) begin
      rx_rd <= rx_rd + 1;
      if (mb_empty) gate_viol <= gate_viol + 1;
    end
    if (mb_wr_en && mb_rd_en) gate_viol <= gate_viol + 1;
    if (rsp_valid && rsp_ready) begin
      rsp_log[rsp_n[10:0]] <= rsp_data;
      rsp_n <= rsp_n + 1;
    end
    if (pay_valid && pay_ready) pay_idx <= pay_idx + 1;
    if (req_valid && req_ready) acc_cnt <= acc_cnt + 1;
    if (done) begin
      done_cnt <= done_cnt + 1;
      last_st <= done_status;
    end
  end

  always @(negedge clk) begin
    full_rnd  <= stress && ($urandom % 10 < 3);
    empty_rnd <= stress && ($urandom % 10 < 3);
    pay_en    <= !stress || ($urandom % 10 < 7);
    rsp_ready <= !stress || ($urandom % 10 < 7);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] be_byte(input logic [31:0] v, input int k);
    return v[31 - 8*k -: 8];
  endfunction

  task automatic push_reply(input logic [7:0] o, input logic [7:0] m, input int decl,
                            input int provide, input bit put_addr, input logic [23:0] a);
    rx_q[rx_n[10:0]] = o;           rx_hi[rx_n[10:0]] = $urandom;
    rx_q[(rx_n+1) & 2047] = m;      rx_hi[(rx_n+1) & 2047] = $urandom;
    rx_q[(rx_n+2) & 2047] = decl[15:8]; rx_hi[(rx_n+2) & 2047] = $urandom;
    rx_q[(rx_n+3) & 2047] = decl[7:0];  rx_hi[(rx_n+3) & 2047] = $urandom;
    for (int i = 0; i < provide; i++) begin
      rx_q[(rx_n+4+i) & 2047] = $urandom;
      rx_hi[(rx_n+4+i) & 2047] = $urandom;
      if (put_addr && i >= 2 && i <= 4) rx_q[(rx_n+4+i) & 2047] = be_byte({8'h00, a}, i - 1);
    end
    rx_n = rx_n + 4 + provide;
  endtask

  task automatic run_cmd(input logic [1:0] kind, input logic [7:0] opc, input logic [7:0] mdl,
                         input int plen, input logic [15:0] addr, input logic [7:0] sb,
                         input logic [7:0] nb, input logic [31:0] val, input bit ex,
                         input int rlen, input bit chk, input logic [23:0] caddr,
                         input bit tx_blocked, input int exp_st, input int exp_rsp,
                         input int exp_used, input string tag);
    int tx_b, rsp_b, rx_b, d0, a0, nexp, l16, mism;
    logic [7:0] ex_b [0:31];
    tx_b = tx_n; rsp_b = rsp_n; rx_b = rx_rd; d0 = done_cnt; a0 = acc_cnt;
    l16 = (kind == 2'd1) ? 6 : (kind == 2'd2) ? 8 : plen;
    ex_b[0] = opc; ex_b[1] = mdl; ex_b[2] = l16[15:8]; ex_b[3] = l16[7:0];
    if (kind == 2'd1) begin
      ex_b[4] = addr[15:8]; ex_b[5] = addr[7:0];
      for (int k = 0; k < 4; k++) ex_b[6+k] = be_byte(val, k);
    end else if (kind == 2'd2) begin
      ex_b[4] = addr[15:8]; ex_b[5] = addr[7:0]; ex_b[6] = sb; ex_b[7] = nb;
      for (int k = 0; k < 4; k++) ex_b[8+k] = be_byte(val, k);
    end else begin
      for (int k = 0; k < plen; k++) begin
        pay_mem[(pay_n+k) & 2047] = $urandom;
        ex_b[4+k] = pay_mem[(pay_n+k) & 2047];
      end
      pay_n = pay_n + plen;
    end
    nexp = tx_blocked ? 0 : 4 + l16;
    @(negedge clk);
    req_kind = kind; req_opcode = opc; req_module = mdl; req_len = plen[15:0];
    req_addr = addr; req_start = sb; req_bits = nb; req_value = val;
    req_expect = ex; req_rsp_len = rlen[15:0]; req_chk_addr = chk; req_addr24 = caddr;
    req_valid = 1'b1;
    while (acc_cnt == a0) @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    check(int'(last_st) == exp_st, {tag, " status"}, int'(last_st), exp_st);
    mism = 0;
    for (int k = 0; k < nexp && k < 32; k++)
      if (tx_log[(tx_b+k) & 2047] !== ex_b[k]) mism++;
    check((tx_n - tx_b) == nexp && mism == 0, {tag, " tx bytes (R1)"}, tx_n - tx_b, nexp);
    mism = 0;
    for (int k = 0; k < exp_rsp; k++)
      if (rsp_log[(rsp_b+k) & 2047] !== rx_q[(rx_b+4+k) & 2047]) mism++;
    check((rsp_n - rsp_b) == exp_rsp && mism == 0, {tag, " reply stream"}, rsp_n - rsp_b, exp_rsp);
    check((rx_rd - rx_b) == exp_used, {tag, " bytes consumed"}, rx_rd - rx_b, exp_used);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pl, rl;
    bit ex, mis;
    logic [7:0] o, m;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R12: reset state
    check(req_ready === 1'b1, "R12 reset req_ready", int'(req_ready), 1);
    check(done === 1'b0 && mb_wr_en === 1'b0 && mb_rd_en === 1'b0 && rsp_valid === 1'b0,
          "R12 reset outputs quiet", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: register write, no reply
    run_cmd(2'd1, 8'h05, 8'h01, 0, 16'hA1B2, 8'h00, 8'h00, 32'hC3D4E5F6, 0, 0, 0, 24'h0,
            0, 0, 0, 0, "R5 reg write");
    // R6: field write with empty matching reply
    push_reply(8'h06, 8'h01, 0, 0, 0, 24'h0);
    run_cmd(2'd2, 8'h06, 8'h01, 0, 16'h0F1E, 8'd4, 8'd1, 32'h89ABCDEF, 1, 0, 0, 24'h0,
            0, 0, 0, 4, "R6 field write");
    // R4 zero-length raw, R3 upper read bits are garbage, R7 reply streamed
    push_reply(8'h11, 8'h01, 2, 2, 0, 24'h0);
    run_cmd(2'd0, 8'h11, 8'h01, 0, 16'h0, 8'h0, 8'h0, 32'h0, 1, 2, 0, 24'h0,
            0, 0, 2, 6, "R4 R3 R7 zero-length");
    // R11: address echo correct
    push_reply(8'h22, 8'h01, 5, 5, 1, 24'h12_34_56);
    run_cmd(2'd0, 8'h22, 8'h01, 6, 16'h0, 8'h0, 8'h0, 32'h0, 1, 5, 1, 24'h12_34_56,
            0, 0, 5, 9, "R11 addr ok");
    // R11: address echo wrong in middle byte
    push_reply(8'h22, 8'h01, 5, 5, 1, 24'h12_99_56);
    run_cmd(2'd0, 8'h22, 8'h01, 6, 16'h0, 8'h0, 8'h0, 32'h0, 1, 5, 1, 24'h12_34_56,
            0, 2, 5, 9, "R11 addr bad");
    // R8: opcode mismatch drained
    push_reply(8'h31, 8'h01, 3, 3, 0, 24'h0);
    run_cmd(2'd0, 8'h30, 8'h01, 1, 16'h0, 8'h0, 8'h0, 32'h0, 1, 3, 0, 24'h0,
            0, 2, 0, 7, "R8 opcode mismatch");
    // R8: length mismatch drained, mailbox stays aligned
    push_reply(8'h32, 8'h01, 4, 4, 0, 24'h0);
    run_cmd(2'd0, 8'h32, 8'h01, 0, 16'h0, 8'h0, 8'h0, 32'h0, 1, 2, 0, 24'h0,
            0, 2, 0, 8, "R8 length mismatch");
    // R9: full held high, nothing written
    full_force = 1'b1;
    run_cmd(2'd1, 8'h40, 8'h01, 0, 16'h1234, 8'h0, 8'h0, 32'h1, 0, 0, 0, 24'h0,
            1, 1, 0, 0, "R9 tx timeout");
    full_force = 1'b0;
    // R9: reply never arrives
    run_cmd(2'd0, 8'h41, 8'h02, 2, 16'h0, 8'h0, 8'h0, 32'h0, 1, 1, 0, 24'h0,
            0, 1, 0, 0, "R9 rx timeout");
    // R10: mismatch declares 5, only 2 supplied
    push_reply(8'h43, 8'h02, 5, 2, 0, 24'h0);
    run_cmd(2'd0, 8'h42, 8'h02, 0, 16'h0, 8'h0, 8'h0, 32'h0, 1, 5, 0, 24'h0,
            0, 1, 0, 6, "R10 drain timeout");
    // random traffic with flag and handshake stalls (R2 R4 R7 R8)
    stress = 1'b1;
    for (int it = 0; it < 24; it++) begin
      pl = $urandom % 13; rl = $urandom % 7; ex = $urandom % 2;
      mis = ex && ($urandom % 4 == 0);
      o = $urandom; m = $urandom;
      if (ex) push_reply(mis ? (o ^ 8'h40) : o, m, rl, rl, 0, 24'h0);
      run_cmd(2'd0, o, m, pl, 16'h0, 8'h0, 8'h0, 32'h0, ex, rl, 0, 24'h0,
              0, mis ? 2 : 0, (ex && !mis) ? rl : 0, ex ? 4 + rl : 0, "R7 R8 random");
    end
    stress = 1'b0;
    repeat (4) @(negedge clk);
    check(gate_viol == 0, "R2 strobe gating", gate_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule